// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block adds or subtracts two packed 64-bit operands. Its carry chain can be cut at run time into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Each lane works on its own, so no carry or borrow ever crosses from one lane into the next. A media or signal-processing datapath uses it to work on short vectors of samples in a single operation.

Each lane can return the plain two's-complement result, which wraps around on overflow. It can instead return a clamped result, which is pinned at the largest or smallest value the lane can hold. A signedness input selects the clamping limits and the meaning of the overflow flag. Operands and controls are sampled on a rising clock edge. The packed result and one overflow flag per 8-bit slice are registered and appear after that edge.

Top module: `simd_sat_adder`

## Requirements
- R1: The `mode` input sets the lane width: 0 gives 8-bit lanes, 1 gives 16-bit lanes, 2 gives 32-bit lanes and 3 gives one 64-bit lane. With `sub`=0 and `sat`=0, each lane of `sum` is the sum of the matching lanes of `a` and `b`, modulo 2^lane width. No carry passes into the next lane.
- R2: With `sub`=1 and `sat`=0, each lane of `sum` is a + (~b) + 1 modulo 2^lane width. No borrow passes into the next lane.
- R3: With `sgn`=1 and `sub`=0, a lane's flag is set only when both operand signs are equal and the sign of the wrapped result differs from them.
- R4: With `sgn`=1 and `sub`=1, a lane's flag is set only when a is non-negative, b is negative and the result sign is 1. It is also set when a is negative, b is non-negative and the result sign is 0.
- R5: A signed add of operands whose signs differ never sets the lane flag.
- R6: With `sgn`=0, the lane flag is the carry out of the lane on an add. On a subtract it is set when b > a, taken as unsigned values.
- R7: With `sat`=1 and `sgn`=1, a flagged lane returns the largest positive value (0x7F..F) when a is non-negative. It returns the most negative value (0x80..0) when a is negative.
- R8: With `sat`=1 and `sgn`=0, a flagged lane returns all ones on an add and zero on a subtract.
- R9: `ovf` has one bit per 8-bit slice, with bit i covering `sum[8i+7:8i]`. Every slice of a lane carries that lane's flag. The flag is reported whether or not `sat` is set.
- R10: `sum` and `ovf` update on the rising edge that samples the inputs. While `rst_n` is low, both read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64 bits) |
| sub | input | 1 | 1 subtracts b from a, 0 adds |
| sat | input | 1 | 1 clamps flagged lanes, 0 wraps |
| sgn | input | 1 | 1 treats lanes as signed, 0 as unsigned |
| a | input | 64 | Packed first operand |
| b | input | 64 | Packed second operand |
| sum | output | 64 | Registered packed result |
| ovf | output | 8 | Registered overflow flag per 8-bit slice |

## Verification
Two effects can fall in the same cycle: a clamp in one lane and a carry or borrow that the neighbouring lane must not receive. The tests provoke this with operands in which one lane overflows and saturates while the lane next to it sits at all ones or all zeros. Any carry that leaked across the boundary would then change the neighbour's value. Each lane is judged against a separate per-lane reference that computes the result with wide arithmetic on the extracted lane values. The whole result and the replicated flags are compared in every mode.

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int WIDTH = 64,
  parameter int SLICE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               sub,
  input  logic               sat,
  input  logic               sgn,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [WIDTH-1:0]   sum,
  output logic [WIDTH/SLICE-1:0] ovf
);
  localparam int NS = WIDTH / SLICE;

  logic [WIDTH-1:0] bb, raw, res_n;
  logic [NS-1:0]    cout, ovf_n;
  int               wl;

  assign bb = b ^ {WIDTH{sub}};

  always_comb begin
    wl = 1 << mode;
    if (wl > NS) wl = NS;
  end

  always_comb begin
    logic             c;
    logic [SLICE:0]   t;
    c = 1'b0;
    raw = '0;
    cout = '0;
    for (int i = 0; i < NS; i++) begin
      if (i % wl == 0) c = sub;
      t = {1'b0, a[i*SLICE +: SLICE]} + {1'b0, bb[i*SLICE +: SLICE]} + {{SLICE{1'b0}}, c};
      raw[i*SLICE +: SLICE] = t[SLICE-1:0];
      cout[i] = t[SLICE];
      c = t[SLICE];
    end
  end

  always_comb begin
    int   top;
    logic as, bs, rs, sov, uov;
    res_n = raw;
    ovf_n = '0;
    for (int i = 0; i < NS; i++) begin
      top = i | (wl - 1);
      as  = a[top*SLICE + SLICE-1];
      bs  = bb[top*SLICE + SLICE-1];
      rs  = raw[top*SLICE + SLICE-1];
      sov = (as == bs) && (rs != as);
      uov = cout[top] ^ sub;
      ovf_n[i] = sgn ? sov : uov;
      if (sat && ovf_n[i]) begin
        if (!sgn)
          res_n[i*SLICE +: SLICE] = {SLICE{~sub}};
        else if (i == top)
          res_n[i*SLICE +: SLICE] = {as, {(SLICE-1){~as}}};
        else
          res_n[i*SLICE +: SLICE] = {SLICE{~as}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      ovf <= '0;
    end else begin
      sum <= res_n;
      ovf <= ovf_n;
    end
  end

  // R9
  replicate_16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |=> (ovf[0] == ovf[1]) && (ovf[2] == ovf[3]) &&
                       (ovf[4] == ovf[5]) && (ovf[6] == ovf[7]));

  // R5
  opposite_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && sgn && !sub && a[WIDTH-1] != b[WIDTH-1]) |=> !ovf[NS-1]);

  // R7
  signed_pos_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sat && sgn && !sub && !a[SLICE-1] && !b[SLICE-1]) |=> !sum[SLICE-1]);

  // R8
  unsigned_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sat && !sgn && !sub) |=> (sum[SLICE-1:0] >= $past(a[SLICE-1:0])));

  // R8
  unsigned_sub_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sat && !sgn && sub) |=> (sum[SLICE-1:0] <= $past(a[SLICE-1:0])));

  // R6
  unsigned_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !sat && !sgn && !sub) |=>
      (ovf[0] == ({1'b0, $past(a[SLICE-1:0])} + {1'b0, $past(b[SLICE-1:0])} > (2**SLICE - 1))));
endmodule

// File: tb/simd_sat_adder_test.sv
`timescale 1ns/1ps
module simd_sat_adder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 0;
  logic sub = 0, sat = 0, sgn = 0;
  logic [63:0] a = 0, b = 0, sum;
  logic [7:0] ovf;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  simd_sat_adder uut (.clk(clk), .rst_n(rst_n), .mode(mode), .sub(sub), .sat(sat),
                      .sgn(sgn), .a(a), .b(b), .sum(sum), .ovf(ovf));

  logic [63:0] exp_sum;
  logic [7:0]  exp_ovf;

  task automatic model(input logic [1:0] m, input logic s, input logic st, input logic sg,
                       input logic [63:0] x, input logic [63:0] y);
    int w = 8 << m;
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    exp_sum = 0; exp_ovf = 0;
    for (int k = 0; k < 64 / w; k++) begin
      logic [64:0] xv, yv, r;
      logic xs, ys, rs, f;
      xv = ({1'b0, x} >> (k * w)) & mask;
      yv = ({1'b0, y} >> (k * w)) & mask;
      r  = s ? (xv - yv) : (xv + yv);
      xs = xv[w-1]; ys = yv[w-1]; rs = r[w-1];
      if (sg) f = s ? (xs != ys && rs != xs) : (xs == ys && rs != xs);
      else    f = s ? (yv > xv) : r[w];
      r = r & mask;
      if (st && f) begin
        if (!sg) r = s ? 65'd0 : mask;
        else     r = xs ? (65'd1 << (w - 1)) : (mask >> 1);
      end
      exp_sum = exp_sum | (r[63:0] << (k * w));
      for (int j = 0; j < w / 8; j++) exp_ovf[k * (w / 8) + j] = f;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] gs, input logic [63:0] es,
                       input logic [7:0] go, input logic [7:0] eo);
    checks++;
    if (gs !== es || go !== eo) begin
      errors++;
      $display("FAIL %s sum=%h ovf=%b expected sum=%h ovf=%b", tag, gs, go, es, eo);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] m, input logic s, input logic st,
                       input logic sg, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    mode = m; sub = s; sat = st; sgn = sg; a = x; b = y;
    model(m, s, st, sg, x, y);
    @(posedge clk); #1;
    check(tag, sum, exp_sum, ovf, exp_ovf);
  endtask

  task automatic t_reset;
    check("R10 reset", sum, 64'd0, ovf, 8'd0);
  endtask

  task automatic t_wrap_lanes;
    for (int m = 0; m < 4; m++)
      apply("R1 wrap add", 2'(m), 0, 0, 0, 64'hFF7F_FFFF_80FF_01FF, 64'h0101_0001_8001_FF01);
    apply("R1 lane boundary", 2'd0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
  endtask

  task automatic t_sub;
    for (int m = 0; m < 4; m++)
      apply("R2 wrap sub", 2'(m), 1, 0, 0, 64'h0000_0001_0000_0100, 64'h0001_0002_0001_0001);
  endtask

  task automatic t_signed_add;
    apply("R3 pos+pos", 2'd0, 0, 0, 1, 64'h7F40_0000_0000_0070, 64'h0140_0000_0000_0010);
    apply("R3 neg+neg", 2'd1, 0, 0, 1, 64'h8000_C000_0000_8001, 64'hFFFF_C000_0000_8001);
  endtask

  task automatic t_signed_sub;
    apply("R4 pos-neg", 2'd0, 1, 0, 1, 64'h7F00_0000_0000_0001, 64'hFF00_0000_0000_0080);
    apply("R4 neg-pos", 2'd2, 1, 0, 1, 64'h8000_0000_8000_0001, 64'h0000_0001_0000_0001);
  endtask

  task automatic t_opposite;
    apply("R5 opposite 64", 2'd3, 0, 0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    apply("R5 opposite 8", 2'd0, 0, 1, 1, 64'h7F80_7F80_7F80_7F80, 64'h807F_FF01_8001_80FF);
  endtask

  task automatic t_unsigned;
    apply("R6 carry out", 2'd0, 0, 0, 0, 64'hF000_0000_0000_00FF, 64'h1000_0000_0000_0001);
    apply("R6 borrow", 2'd1, 1, 0, 0, 64'h0000_0005_0000_0001, 64'h0001_0005_0000_0002);
  endtask

  task automatic t_sat_signed;
    apply("R7 clamp 8", 2'd0, 0, 1, 1, 64'h7F80_0000_0000_7F80, 64'h0180_0000_0000_0180);
    apply("R7 clamp 32", 2'd2, 1, 1, 1, 64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001);
    apply("R7 clamp 64", 2'd3, 0, 1, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_sat_unsigned;
    apply("R8 clamp high", 2'd1, 0, 1, 0, 64'hFFFF_0001_FFFF_8000, 64'h0001_0001_FFFF_8000);
    apply("R8 clamp low", 2'd0, 1, 1, 0, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001);
  endtask

  task automatic t_replicate;
    apply("R9 flag 16 wrap", 2'd1, 0, 0, 0, 64'hFFFF_0000_0000_FFFF, 64'h0001_0000_0000_0001);
    apply("R9 flag 32 sat", 2'd2, 0, 1, 1, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000);
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 400; n++)
      apply("R1 R2 sweep", 2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom});
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    #12 rst_n = 1'b1;
    t_wrap_lanes;
    t_sub;
    t_signed_add;
    t_signed_sub;
    t_opposite;
    t_unsigned;
    t_sat_signed;
    t_sat_unsigned;
    t_replicate;
    t_sweep;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule